// File: doc/BRIEF.md
# Character Attribute Realignment and Protect Marking

This block sits in a character-cell video path between the row controllers and the dot serializer. Each character clock it takes the visual attribute flags of one character cell (blank, underline, video suppress, reverse, half-intensity and two general-purpose flags), together with one spare code bit from a second controller. These flags are valid only during their own character cycle. The glyph data for the same character reaches the serializer later, because the glyph store needs more than one character cycle to answer. The block holds the attributes in a delay line of parameterised depth, so that they arrive in the same cycle as that glyph data.

At the far end of the delay line, the block forms a protect mark. The mark is the OR of the delayed half-intensity flag and the delayed spare code bit. Any protected cell therefore shows dim, which is driven on a separate intensity pin. The block also applies the delayed attributes to the serial dot for the current scan line, producing the final video dot.

The flow is a raster stream and cannot stall, so there is no ready signal and no back-pressure. A cell-valid flag travels alongside the attributes. When the delayed flag is low, the dot and intensity outputs stay dark.

Top module: `char_attr_pipe`

## Requirements
- R1: While reset is asserted, and directly after it, every output is 0, whatever the inputs are. The delay line is cleared, so nothing lights until valid cells have passed through it.
- R2: The cell-valid flag and the blank, underline, suppress, reverse and half-intensity flags sampled at one clock edge all appear on their outputs exactly DELAY_CYC clock edges later, with the same depth for every bit.
- R3: The two general-purpose flags pass through the same delay unchanged, in bit order.
- R4: protect_o equals the OR of the delayed half-intensity flag and the delayed spare code bit.
- R5: dim_o is 1 exactly when the delayed cell is valid and protect_o is 1. The dot value is not affected by it.
- R6: When the delayed cell is valid and blank is set, dot_o is 0 regardless of the dot, reverse, suppress or underline.
- R7: When the delayed cell is valid, not blanked and video suppress is set, the dot before reversal is 0. dot_o therefore equals the delayed reverse flag.
- R8: When the delayed cell is valid and neither blank nor suppress is set, reverse set gives dot_o as the inverse of the dot before reversal. Reverse clear passes that dot unchanged.
- R9: When the delayed cell is valid, not blanked, not suppressed and underlined, the dot before reversal is forced to 1 on the scan line whose number equals uline_row_i. On any other scan line, underline has no effect.
- R10: When the delayed cell-valid flag is 0, dot_o and dim_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_valid_i | input | 1 | Attributes of this cycle belong to a displayed cell |
| blank_i | input | 1 | Blank attribute |
| uline_i | input | 1 | Underline attribute |
| vsup_i | input | 1 | Video suppress attribute |
| rev_i | input | 1 | Reverse video attribute |
| half_i | input | 1 | Half-intensity attribute from the primary controller |
| gp_i | input | 2 | General-purpose attribute flags |
| sec_lsb_i | input | 1 | Lowest code bit from the secondary controller |
| scan_line_i | input | SCAN_W | Scan line of the delayed cell now being serialized |
| uline_row_i | input | SCAN_W | Scan line on which underline is drawn |
| dot_i | input | 1 | Serial glyph dot of the delayed cell |
| cell_valid_o | output | 1 | Delayed cell-valid flag |
| blank_o | output | 1 | Delayed blank |
| uline_o | output | 1 | Delayed underline |
| vsup_o | output | 1 | Delayed video suppress |
| rev_o | output | 1 | Delayed reverse |
| half_o | output | 1 | Delayed half-intensity |
| gp_o | output | 2 | Delayed general-purpose flags |
| protect_o | output | 1 | Protect mark of the delayed cell |
| dim_o | output | 1 | Reduced-intensity control |
| dot_o | output | 1 | Final video dot |

## Verification
The bench builds the block with DELAY_CYC = 2 and SCAN_W = 4. A two-deep line exercises the handoff between stages, so a bit that skips or repeats a stage shows up as a one-cycle slip against the reference queue. The 4-bit scan number lets the stimulus sweep an eleven-line cell, so the underline row is both hit and missed while the other attributes are active or inactive.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int unsigned GP_W = 2;

  // one character cell's attribute set, eight bits wide
  typedef struct packed {
    logic            prot_src;
    logic [GP_W-1:0] gp;
    logic            half;
    logic            rev;
    logic            vsup;
    logic            uline;
    logic            blank;
  } cell_attr_t;

  localparam int unsigned ATTR_W = $bits(cell_attr_t);

endpackage

// File: rtl/cap_delay_line.sv
module cap_delay_line #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_regs
      logic [WIDTH-1:0] stg_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) stg_q[k] <= '0;
        end else begin
          stg_q[0] <= d_i;
          for (int k = 1; k < DEPTH; k++) stg_q[k] <= stg_q[k-1];
        end
      end

      assign q_o = stg_q[DEPTH-1];

      // R2
      first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg_q[0] == $past(d_i));

      for (genvar s = 1; s < DEPTH; s++) begin : g_stage_chk
        // R2
        stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
          $past(rst_n) |-> stg_q[s] == $past(stg_q[s-1]));
      end
    end
  endgenerate

endmodule

// File: rtl/cap_protect.sv
module cap_protect (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic half_i,
  input  logic sec_i,
  output logic protect_o,
  output logic dim_o
);

  assign protect_o = half_i | sec_i;
  assign dim_o     = valid_i & protect_o;

  // R4
  sec_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_i |-> protect_o);

  // R5
  protected_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && protect_o) |-> dim_o);

  // R10
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !dim_o);

endmodule

// File: rtl/cap_dot_mod.sv
module cap_dot_mod #(
  parameter int unsigned SCAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              blank_i,
  input  logic              vsup_i,
  input  logic              rev_i,
  input  logic              uline_i,
  input  logic [SCAN_W-1:0] scan_line_i,
  input  logic [SCAN_W-1:0] uline_row_i,
  input  logic              dot_i,
  output logic              dot_o
);

  logic ul_hit;
  logic pre_rev;
  logic post_rev;

  assign ul_hit   = uline_i && (scan_line_i == uline_row_i);
  assign pre_rev  = vsup_i ? 1'b0 : (dot_i | ul_hit);
  assign post_rev = pre_rev ^ rev_i;
  assign dot_o    = valid_i & ~blank_i & post_rev;

  // R6
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && blank_i) |-> !dot_o);

  // R7
  vsup_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !blank_i && vsup_i) |-> dot_o == rev_i);

  // R9
  uline_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !blank_i && !vsup_i && uline_i && scan_line_i == uline_row_i)
      |-> dot_o == !rev_i);

  // R10
  idle_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !dot_o);

endmodule

// File: rtl/char_attr_pipe.sv
module char_attr_pipe
  import cap_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 1,
  parameter int unsigned SCAN_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid_i,
  input  logic              blank_i,
  input  logic              uline_i,
  input  logic              vsup_i,
  input  logic              rev_i,
  input  logic              half_i,
  input  logic [1:0]        gp_i,
  input  logic              sec_lsb_i,
  input  logic [SCAN_W-1:0] scan_line_i,
  input  logic [SCAN_W-1:0] uline_row_i,
  input  logic              dot_i,
  output logic              cell_valid_o,
  output logic              blank_o,
  output logic              uline_o,
  output logic              vsup_o,
  output logic              rev_o,
  output logic              half_o,
  output logic [1:0]        gp_o,
  output logic              protect_o,
  output logic              dim_o,
  output logic              dot_o
);

  localparam int unsigned WORD_W = ATTR_W + 1;

  cell_attr_t        in_attr;
  cell_attr_t        dl_attr;
  logic              dl_valid;
  logic [WORD_W-1:0] in_word;
  logic [WORD_W-1:0] dl_word;

  always_comb begin
    in_attr          = '0;
    in_attr.blank    = blank_i;
    in_attr.uline    = uline_i;
    in_attr.vsup     = vsup_i;
    in_attr.rev      = rev_i;
    in_attr.half     = half_i;
    in_attr.gp       = gp_i;
    in_attr.prot_src = sec_lsb_i;
  end

  assign in_word = {cell_valid_i, in_attr};

  cap_delay_line #(
    .WIDTH (WORD_W),
    .DEPTH (DELAY_CYC)
  ) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (in_word),
    .q_o   (dl_word)
  );

  assign dl_valid = dl_word[WORD_W-1];
  assign dl_attr  = cell_attr_t'(dl_word[ATTR_W-1:0]);

  assign cell_valid_o = dl_valid;
  assign blank_o      = dl_attr.blank;
  assign uline_o      = dl_attr.uline;
  assign vsup_o       = dl_attr.vsup;
  assign rev_o        = dl_attr.rev;
  assign half_o       = dl_attr.half;
  assign gp_o         = dl_attr.gp;

  cap_protect u_protect (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (dl_valid),
    .half_i    (dl_attr.half),
    .sec_i     (dl_attr.prot_src),
    .protect_o (protect_o),
    .dim_o     (dim_o)
  );

  cap_dot_mod #(
    .SCAN_W (SCAN_W)
  ) u_dot (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (dl_valid),
    .blank_i     (dl_attr.blank),
    .vsup_i      (dl_attr.vsup),
    .rev_i       (dl_attr.rev),
    .uline_i     (dl_attr.uline),
    .scan_line_i (scan_line_i),
    .uline_row_i (uline_row_i),
    .dot_i       (dot_i),
    .dot_o       (dot_o)
  );

endmodule

// File: tb/test_char_attr_pipe.sv
`timescale 1ns/1ps
module test_char_attr_pipe;

  localparam int DLY = 2;
  localparam int SW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v_i = 0, bl_i = 0, ul_i = 0, vs_i = 0, rv_i = 0, hf_i = 0, sec_i = 0, dot_i = 0;
  logic [1:0] gp_i = '0;
  logic [SW-1:0] sl_i = '0, ur_i = '0;
  logic v_o, bl_o, ul_o, vs_o, rv_o, hf_o, prot_o, dim_o, dot_o;
  logic [1:0] gp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench word order: {valid, sec, gp[1:0], half, rev, vsup, uline, blank}
  logic [8:0] hist [DLY];

  always #4 clk = ~clk;

  char_attr_pipe #(.DELAY_CYC(DLY), .SCAN_W(SW)) i_char_attr_pipe (
    .clk(clk), .rst_n(rst_n), .cell_valid_i(v_i), .blank_i(bl_i), .uline_i(ul_i),
    .vsup_i(vs_i), .rev_i(rv_i), .half_i(hf_i), .gp_i(gp_i), .sec_lsb_i(sec_i),
    .scan_line_i(sl_i), .uline_row_i(ur_i), .dot_i(dot_i),
    .cell_valid_o(v_o), .blank_o(bl_o), .uline_o(ul_o), .vsup_o(vs_o), .rev_o(rv_o),
    .half_o(hf_o), .gp_o(gp_o), .protect_o(prot_o), .dim_o(dim_o), .dot_o(dot_o));

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [8:0] h;
    logic pix, ed, ep;
    string tag;
    h = hist[DLY-1];
    chk("R2 attrs", {v_o, hf_o, rv_o, vs_o, ul_o, bl_o}, {h[8], h[4], h[3], h[2], h[1], h[0]});
    chk("R3 gp", {7'd0, gp_o}, {7'd0, h[6:5]});
    ep = h[4] | h[7];
    chk("R4 protect", {8'd0, prot_o}, {8'd0, ep});
    chk("R5 dim", {8'd0, dim_o}, {8'd0, h[8] & ep});
    if (!h[8]) begin ed = 0; tag = "R10 dot"; end
    else if (h[0]) begin ed = 0; tag = "R6 dot"; end
    else begin
      if (h[2]) pix = 0;
      else pix = dot_i || (h[1] && sl_i == ur_i);
      ed = h[3] ? !pix : pix;
      if (h[2]) tag = "R7 dot";
      else if (h[1] && sl_i == ur_i) tag = "R9 dot";
      else if (h[3]) tag = "R8 dot";
      else tag = "R2 dot";
    end
    chk(tag, {8'd0, dot_o}, {8'd0, ed});
  endtask

  task automatic step(input logic [8:0] w, input logic d, input logic [SW-1:0] sl,
                      input logic [SW-1:0] ur);
    @(negedge clk);
    {v_i, sec_i, gp_i, hf_i, rv_i, vs_i, ul_i, bl_i} = w;
    dot_i = d; sl_i = sl; ur_i = ur;
    #1;
    compare();
    @(posedge clk);
    for (int k = DLY - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = w;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DLY; k++) hist[k] = '0;
    // R1: outputs stay dark under reset even with live inputs
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      {v_i, sec_i, gp_i, hf_i, rv_i, vs_i, ul_i, bl_i} = 9'h1FF;
      dot_i = 1; sl_i = 4'd3; ur_i = 4'd3;
      #1;
      chk("R1 reset", {v_o, bl_o, ul_o, vs_o, rv_o, hf_o, prot_o, dim_o, dot_o}, 9'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    {v_i, sec_i, gp_i, hf_i, rv_i, vs_i, ul_i, bl_i} = '0;
    #1;
    chk("R1 release", {v_o, bl_o, ul_o, vs_o, rv_o, hf_o, prot_o, dim_o, dot_o}, 9'd0);

    // directed patterns: {valid, sec, gp, half, rev, vsup, uline, blank}
    step(9'b1_0_00_0_0_0_0_0, 1, 4'd0, 4'd9);   // R2 plain
    step(9'b1_0_10_0_0_0_0_1, 1, 4'd0, 4'd9);   // R6 blank
    step(9'b1_0_01_0_1_0_0_1, 0, 4'd1, 4'd9);   // R6 blank beats reverse
    step(9'b1_1_00_0_0_1_0_0, 1, 4'd2, 4'd9);   // R7 suppress, R4 sec
    step(9'b1_0_00_1_1_1_0_0, 0, 4'd3, 4'd9);   // R7 suppress+reverse, R5
    step(9'b1_0_11_0_1_0_0_0, 0, 4'd4, 4'd9);   // R8 reverse
    step(9'b1_0_00_0_1_0_1_0, 1, 4'd9, 4'd9);   // R9 underline hit under reverse
    step(9'b1_0_00_0_0_0_1_0, 0, 4'd9, 4'd9);   // R9 underline hit
    step(9'b1_0_00_0_0_0_1_0, 0, 4'd8, 4'd9);   // R9 miss
    step(9'b0_1_00_1_1_0_1_0, 1, 4'd9, 4'd9);   // R10 invalid
    step(9'b0_0_00_0_0_0_0_0, 1, 4'd9, 4'd9);
    step(9'b0_0_00_0_0_0_0_0, 1, 4'd9, 4'd9);
    step(9'b0_0_00_0_0_0_0_0, 1, 4'd9, 4'd9);

    for (int n = 0; n < 600; n++) begin
      logic [8:0] w;
      w = 9'($urandom);
      step(w, 1'($urandom), 4'($urandom % 11), 4'd9);
    end
    step(9'd0, 0, 4'd0, 4'd9);
    step(9'd0, 0, 4'd0, 4'd9);
    step(9'd0, 0, 4'd0, 4'd9);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule